// File: doc/BRIEF.md
# Boot-Block Sector Decode and Write Guard

This block sits between the command interface of a flash-style array and its program/erase engine. It turns a byte or word address into the index of the erase block that holds it, and reports that block's size class. The array has one 64 KB region that is split into four smaller blocks, a 16 KB boot block, two 8 KB parameter blocks and a 32 KB block. A build-time parameter places that split region at the top of the address space or at the bottom. All other 64 KB regions are uniform blocks.

For each program or erase request the block decides whether the request may go ahead. It weighs the following:
- a bank of per-block protect bits;
- an active-low write-protect pin that locks the boot block;
- a temporary-unprotect flag, which the pad logic raises when the reset pin sits at elevated voltage;
- the hardware reset pin;
- a digital supply-lockout indication;
- the busy state of the engine.

A granted request raises a one-cycle grant pulse. A refused request raises a one-cycle ignored pulse. The block also drives the pull-down enable of the open-drain ready/busy pin. It flags an abort when lockout arrives while an operation is running.

Top module: `boot_sector_guard`

## Requirements
- R1: With the split region at the bottom, byte addresses decode as follows. Addresses 0x000000–0x003FFF go to index 0 with size code 0 (16 KB). Addresses 0x004000–0x005FFF go to index 1 with code 1 (8 KB), and 0x006000–0x007FFF go to index 2 with code 1. Addresses 0x008000–0x00FFFF go to index 3 with code 2 (32 KB). For any other address, region r = addr>>16 goes to index r+3 with code 3 (64 KB).
- R2: With the split region at the top, byte addresses decode as follows. Region r below 63 goes to index r with code 3. Addresses 0x3F0000–0x3F7FFF go to index 63 with code 2. Addresses 0x3F8000–0x3F9FFF go to index 64 with code 1, and 0x3FA000–0x3FBFFF go to index 65 with code 1. Addresses 0x3FC000–0x3FFFFF go to index 66 with code 0, which is the boot block.
- R3: When word_mode_i is high, addr_i is a word address. Bit 21 is ignored, and the byte address is addr_i[20:0] shifted left by one. For example, word 0x1FE000 is the top boot block.
- R4: The 67 protect bits clear to unprotected on rst_ni. prot_load_i writes prot_data_i at the clock edge, and bit i protects block index i. A load is seen by requests from the next cycle on.
- R5: Index, size, grant_o and ignored_o are registered and appear one cycle after the inputs. grant_o and ignored_o are never high together. Neither is high in the cycle after a cycle with req_i low.
- R6: A request to the boot block while wp_ni is low is refused, whatever the protect bit and the temporary-unprotect flag say.
- R7: While temp_unprot_i is high, the protect bits are disregarded. The exception is that the boot block stays locked by a low wp_ni.
- R8: A request is refused while lockout_i is high, while hw_reset_ni is low, or while busy_i is high.
- R9: rb_low_o, the pull-down enable of the ready/busy pin, equals busy_i delayed by one cycle. A low value means the pin is released to high impedance.
- R10: abort_o is high in the cycle after any cycle in which lockout_i and busy_i are both high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| addr_i | input | 22 | Byte address, or word address in word mode |
| word_mode_i | input | 1 | High selects 16-bit addressing |
| req_i | input | 1 | Program or erase request this cycle |
| prot_load_i | input | 1 | Load the protect-bit bank |
| prot_data_i | input | 67 | New protect bits, one per block index |
| wp_ni | input | 1 | Write-protect pin, low locks the boot block |
| temp_unprot_i | input | 1 | Temporary unprotect of all blocks |
| hw_reset_ni | input | 1 | Hardware reset pin, active low |
| lockout_i | input | 1 | Supply below lockout threshold |
| busy_i | input | 1 | Program/erase engine busy |
| blk_idx_o | output | 7 | Decoded block index |
| blk_size_o | output | 2 | Size code: 0=16K, 1=8K, 2=32K, 3=64K |
| grant_o | output | 1 | One-cycle request accepted |
| ignored_o | output | 1 | One-cycle request refused |
| rb_low_o | output | 1 | Drive ready/busy low |
| abort_o | output | 1 | Running operation aborted by lockout |

## Verification
The bench builds the block twice with default widths, once with TOP_BOOT=1 and once with TOP_BOOT=0, and drives both from the same stimulus. Both split-region layouts are therefore compared on every address, including every edge of the four small blocks in byte and word addressing. Each layout places the boot block at a different index, 66 or 0. As a result, the interaction of the protect bits, write protect and temporary unprotect is exercised at both ends of the protect bank.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;
  typedef enum logic [1:0] {
    SZ_16K = 2'd0,
    SZ_8K  = 2'd1,
    SZ_32K = 2'd2,
    SZ_64K = 2'd3
  } blk_size_e;
endpackage

// File: rtl/boot_blk_decode.sv
module boot_blk_decode
  import boot_guard_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int REGION_W = 16,
  parameter bit TOP_BOOT = 1'b1,
  localparam int REG_BITS = ADDR_W - REGION_W,
  localparam int N_REGION = 1 << REG_BITS,
  localparam int NUM_BLK  = N_REGION + 3,
  localparam int IDX_W    = $clog2(NUM_BLK)
) (
  input  logic [ADDR_W-1:0] byte_addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output blk_size_e         size_o,
  output logic              is_boot_o
);
  localparam logic [REG_BITS-1:0] LAST_REG = '1;
  localparam int SPLIT_BASE = N_REGION - 1;
  localparam logic [IDX_W-1:0] BOOT_IDX = TOP_BOOT ? IDX_W'(NUM_BLK - 1) : '0;

  logic [REG_BITS-1:0] region;
  logic o15, o14, o13;

  assign region = byte_addr_i[ADDR_W-1:REGION_W];
  assign o15    = byte_addr_i[REGION_W-1];
  assign o14    = byte_addr_i[REGION_W-2];
  assign o13    = byte_addr_i[REGION_W-3];

  generate
    if (TOP_BOOT) begin : g_top
      always_comb begin
        idx_o  = IDX_W'(region);
        size_o = SZ_64K;
        if (region == LAST_REG) begin
          if (!o15) begin
            idx_o  = IDX_W'(SPLIT_BASE);
            size_o = SZ_32K;
          end else if (o14) begin
            idx_o  = IDX_W'(SPLIT_BASE + 3);
            size_o = SZ_16K;
          end else begin
            idx_o  = o13 ? IDX_W'(SPLIT_BASE + 2) : IDX_W'(SPLIT_BASE + 1);
            size_o = SZ_8K;
          end
        end
      end
    end else begin : g_bot
      always_comb begin
        idx_o  = IDX_W'(region) + IDX_W'(3);
        size_o = SZ_64K;
        if (region == '0) begin
          if (o15) begin
            idx_o  = IDX_W'(3);
            size_o = SZ_32K;
          end else if (!o14) begin
            idx_o  = '0;
            size_o = SZ_16K;
          end else begin
            idx_o  = o13 ? IDX_W'(2) : IDX_W'(1);
            size_o = SZ_8K;
          end
        end
      end
    end
  endgenerate

  assign is_boot_o = (idx_o == BOOT_IDX);

  // R1 R2: decoded index always addresses a real block
  always_comb begin
    a_r2_idx_in_range: assert (int'(idx_o) < NUM_BLK);
  end
endmodule

// File: rtl/boot_prot_reg.sv
module boot_prot_reg #(
  parameter int NUM_BLK = 67
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [NUM_BLK-1:0] data_i,
  output logic [NUM_BLK-1:0] prot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prot_o <= '0;
    else if (load_i) prot_o <= data_i;
  end

  a_r4_load_applied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> prot_o == $past(data_i));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(prot_o));
endmodule

// File: rtl/boot_grant_policy.sv
module boot_grant_policy #(
  parameter int NUM_BLK = 67,
  localparam int IDX_W  = $clog2(NUM_BLK)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               is_boot_i,
  input  logic [NUM_BLK-1:0] prot_i,
  input  logic               wp_ni,
  input  logic               temp_unprot_i,
  input  logic               hw_reset_ni,
  input  logic               lockout_i,
  input  logic               busy_i,
  output logic               grant_o,
  output logic               ignored_o
);
  logic bit_lock, boot_lock, env_block, deny;

  assign bit_lock  = (int'(idx_i) < NUM_BLK) && prot_i[idx_i] && !temp_unprot_i;
  assign boot_lock = is_boot_i && !wp_ni;  // wins over temporary unprotect
  assign env_block = lockout_i || !hw_reset_ni || busy_i;
  assign deny      = bit_lock || boot_lock || env_block;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o   <= 1'b0;
      ignored_o <= 1'b0;
    end else begin
      grant_o   <= req_i && !deny;
      ignored_o <= req_i && deny;
    end
  end

  a_r6_boot_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_boot_i && !wp_ni) |=> (ignored_o && !grant_o));
  a_r8_env_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (lockout_i || busy_i || !hw_reset_ni)) |=> !grant_o);
endmodule

// File: rtl/boot_rb_drive.sv
module boot_rb_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic lockout_i,
  output logic rb_low_o,
  output logic abort_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_low_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      rb_low_o <= busy_i;
      abort_o  <= busy_i && lockout_i;
    end
  end

  a_r9_rb_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> rb_low_o);
  a_r10_abort_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(busy_i));
endmodule

// File: rtl/boot_sector_guard.sv
module boot_sector_guard
  import boot_guard_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int REGION_W = 16,
  parameter bit TOP_BOOT = 1'b1,
  localparam int N_REGION = 1 << (ADDR_W - REGION_W),
  localparam int NUM_BLK  = N_REGION + 3,
  localparam int IDX_W    = $clog2(NUM_BLK)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               word_mode_i,
  input  logic               req_i,
  input  logic               prot_load_i,
  input  logic [NUM_BLK-1:0] prot_data_i,
  input  logic               wp_ni,
  input  logic               temp_unprot_i,
  input  logic               hw_reset_ni,
  input  logic               lockout_i,
  input  logic               busy_i,
  output logic [IDX_W-1:0]   blk_idx_o,
  output logic [1:0]         blk_size_o,
  output logic               grant_o,
  output logic               ignored_o,
  output logic               rb_low_o,
  output logic               abort_o
);
  logic [ADDR_W-1:0]  byte_addr;
  logic [IDX_W-1:0]   dec_idx;
  blk_size_e          dec_size;
  logic               dec_boot;
  logic [NUM_BLK-1:0] prot_q;

  assign byte_addr = word_mode_i ? {addr_i[ADDR_W-2:0], 1'b0} : addr_i;

  boot_blk_decode #(
    .ADDR_W(ADDR_W), .REGION_W(REGION_W), .TOP_BOOT(TOP_BOOT)
  ) u_decode (
    .byte_addr_i(byte_addr), .idx_o(dec_idx), .size_o(dec_size), .is_boot_o(dec_boot)
  );

  boot_prot_reg #(.NUM_BLK(NUM_BLK)) u_prot (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(prot_load_i),
    .data_i(prot_data_i), .prot_o(prot_q)
  );

  boot_grant_policy #(.NUM_BLK(NUM_BLK)) u_policy (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .idx_i(dec_idx),
    .is_boot_i(dec_boot), .prot_i(prot_q), .wp_ni(wp_ni),
    .temp_unprot_i(temp_unprot_i), .hw_reset_ni(hw_reset_ni),
    .lockout_i(lockout_i), .busy_i(busy_i),
    .grant_o(grant_o), .ignored_o(ignored_o)
  );

  boot_rb_drive u_rb (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .lockout_i(lockout_i),
    .rb_low_o(rb_low_o), .abort_o(abort_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_idx_o  <= '0;
      blk_size_o <= '0;
    end else begin
      blk_idx_o  <= dec_idx;
      blk_size_o <= dec_size;
    end
  end

  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && ignored_o));
  a_r5_no_req_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!grant_o && !ignored_o));
  a_r7_unprot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && temp_unprot_i && wp_ni && hw_reset_ni && !lockout_i && !busy_i)
      |=> grant_o);
endmodule

// File: tb/boot_sector_guard_tb.sv
`timescale 1ns/1ps
module boot_sector_guard_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [21:0] addr;
  logic        word_mode, req, prot_load, wp_n, tunp, hwr_n, lock, busy;
  logic [66:0] prot_data;
  logic [6:0]  idx_t, idx_b;
  logic [1:0]  sz_t, sz_b;
  logic        gnt_t, gnt_b, ign_t, ign_b, rb_t, rb_b, ab_t, ab_b;

  int checks = 0;
  int fails  = 0;

  boot_sector_guard #(.TOP_BOOT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .word_mode_i(word_mode),
    .req_i(req), .prot_load_i(prot_load), .prot_data_i(prot_data),
    .wp_ni(wp_n), .temp_unprot_i(tunp), .hw_reset_ni(hwr_n),
    .lockout_i(lock), .busy_i(busy), .blk_idx_o(idx_t), .blk_size_o(sz_t),
    .grant_o(gnt_t), .ignored_o(ign_t), .rb_low_o(rb_t), .abort_o(ab_t));

  boot_sector_guard #(.TOP_BOOT(1'b0)) u_dut_bot (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .word_mode_i(word_mode),
    .req_i(req), .prot_load_i(prot_load), .prot_data_i(prot_data),
    .wp_ni(wp_n), .temp_unprot_i(tunp), .hw_reset_ni(hwr_n),
    .lockout_i(lock), .busy_i(busy), .blk_idx_o(idx_b), .blk_size_o(sz_b),
    .grant_o(gnt_b), .ignored_o(ign_b), .rb_low_o(rb_b), .abort_o(ab_b));

  // reference state
  bit [66:0] m_prot;
  bit        have_exp;
  int        e_idx[2], e_sz[2], e_gnt[2], e_ign[2], e_rb, e_ab;
  string     e_tag;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // range-based reference map (R1 bottom, R2 top)
  task automatic ref_map(input bit top, input int unsigned ba, output int idx, output int sz);
    if (top) begin
      if (ba >= 32'h3FC000)      begin idx = 66; sz = 0; end
      else if (ba >= 32'h3FA000) begin idx = 65; sz = 1; end
      else if (ba >= 32'h3F8000) begin idx = 64; sz = 1; end
      else if (ba >= 32'h3F0000) begin idx = 63; sz = 2; end
      else                       begin idx = int'(ba >> 16); sz = 3; end
    end else begin
      if (ba < 32'h4000)         begin idx = 0; sz = 0; end
      else if (ba < 32'h6000)    begin idx = 1; sz = 1; end
      else if (ba < 32'h8000)    begin idx = 2; sz = 1; end
      else if (ba < 32'h10000)   begin idx = 3; sz = 2; end
      else                       begin idx = int'(ba >> 16) + 3; sz = 3; end
    end
  endtask

  task automatic compare();
    if (!have_exp) return;
    chk({e_tag, "/R2/R3"}, "top idx",  int'(idx_t), e_idx[0]);
    chk({e_tag, "/R2/R3"}, "top size", int'(sz_t),  e_sz[0]);
    chk({e_tag, "/R1/R3"}, "bot idx",  int'(idx_b), e_idx[1]);
    chk({e_tag, "/R1/R3"}, "bot size", int'(sz_b),  e_sz[1]);
    chk({e_tag, "/R5"}, "top grant",  int'(gnt_t), e_gnt[0]);
    chk({e_tag, "/R5"}, "top ignore", int'(ign_t), e_ign[0]);
    chk({e_tag, "/R5"}, "bot grant",  int'(gnt_b), e_gnt[1]);
    chk({e_tag, "/R5"}, "bot ignore", int'(ign_b), e_ign[1]);
    chk({e_tag, "/R9"},  "rb",    int'(rb_t), e_rb);
    chk({e_tag, "/R9"},  "rb b",  int'(rb_b), e_rb);
    chk({e_tag, "/R10"}, "abort", int'(ab_t), e_ab);
    chk({e_tag, "/R10"}, "abort b", int'(ab_b), e_ab);
  endtask

  task automatic cyc(input string tag, input logic [21:0] a, input bit wm, input bit rq,
                     input bit ld, input logic [66:0] pd, input bit wpn, input bit tu,
                     input bit hr, input bit lk, input bit bz);
    int unsigned ba;
    @(negedge clk);
    compare();
    addr = a; word_mode = wm; req = rq; prot_load = ld; prot_data = pd;
    wp_n = wpn; tunp = tu; hwr_n = hr; lock = lk; busy = bz;
    ba = wm ? (int'(a & 22'h1FFFFF) << 1) : int'(a);
    for (int v = 0; v < 2; v++) begin
      bit top = (v == 0);
      int i, s, boot_i;
      bit deny;
      ref_map(top, ba, i, s);
      boot_i = top ? 66 : 0;
      deny = (m_prot[i] && !tu) || (i == boot_i && !wpn) || lk || !hr || bz;
      e_idx[v] = i; e_sz[v] = s;
      e_gnt[v] = int'(rq && !deny);
      e_ign[v] = int'(rq && deny);
    end
    e_rb = int'(bz); e_ab = int'(bz && lk);
    e_tag = tag;
    have_exp = 1'b1;
    if (ld) m_prot = pd;
  endtask

  // plain request, environment clear
  task automatic rq(input string tag, input logic [21:0] a, input bit wm);
    cyc(tag, a, wm, 1'b1, 1'b0, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [21:0] top_edges[10];
    logic [21:0] bot_edges[10];
    logic [21:0] word_pts[6];
    top_edges = '{22'h3FFFFF, 22'h3FC000, 22'h3FBFFF, 22'h3FA000, 22'h3F9FFF,
                  22'h3F8000, 22'h3F7FFF, 22'h3F0000, 22'h3EFFFF, 22'h000000};
    bot_edges = '{22'h000000, 22'h003FFF, 22'h004000, 22'h005FFF, 22'h006000,
                  22'h007FFF, 22'h008000, 22'h00FFFF, 22'h010000, 22'h3FFFFF};
    word_pts  = '{22'h1FE000, 22'h1FDFFF, 22'h3FE000, 22'h001FFF, 22'h002000, 22'h004000};
    addr = '0; word_mode = 0; req = 0; prot_load = 0; prot_data = '0;
    wp_n = 1; tunp = 0; hwr_n = 1; lock = 0; busy = 1;
    m_prot = '0; have_exp = 0;

    // reset state (R4, R5, R9)
    repeat (3) @(negedge clk);
    chk("R5", "reset grant",  int'(gnt_t | gnt_b), 0);
    chk("R5", "reset ignore", int'(ign_t | ign_b), 0);
    chk("R9", "reset rb",     int'(rb_t | rb_b), 0);
    chk("R10", "reset abort", int'(ab_t | ab_b), 0);
    rst_ni = 1'b1;

    // maps with cleared protect bank: R4 power-on unprotected
    foreach (top_edges[k]) rq("R2/R4", top_edges[k], 1'b0);
    foreach (bot_edges[k]) rq("R1/R4", bot_edges[k], 1'b0);
    foreach (word_pts[k])  rq("R3", word_pts[k], 1'b1);

    // protect everything; load seen on next request only
    cyc("R4", 22'h3FFFFF, 0, 1, 1, '1, 1, 0, 1, 0, 0);
    cyc("R4", 22'h3FFFFF, 0, 1, 0, '0, 1, 0, 1, 0, 0);
    cyc("R4", 22'h000000, 0, 1, 0, '0, 1, 0, 1, 0, 0);
    // temp unprotect with wp high: all granted
    cyc("R7", 22'h3FC000, 0, 1, 0, '0, 1, 1, 1, 0, 0);
    cyc("R7", 22'h003000, 0, 1, 0, '0, 1, 1, 1, 0, 0);
    // temp unprotect with wp low: boot stays locked, others pass
    cyc("R6/R7", 22'h3FC000, 0, 1, 0, '0, 0, 1, 1, 0, 0);
    cyc("R6/R7", 22'h000100, 0, 1, 0, '0, 0, 1, 1, 0, 0);
    cyc("R7", 22'h3FA000, 0, 1, 0, '0, 0, 1, 1, 0, 0);
    // clear protect; wp low alone locks boot
    cyc("R6", 22'h000000, 0, 0, 1, '0, 1, 0, 1, 0, 0);
    cyc("R6", 22'h3FFFFF, 0, 1, 0, '0, 0, 0, 1, 0, 0);
    cyc("R6", 22'h1FFFFF, 1, 1, 0, '0, 0, 0, 1, 0, 0);
    cyc("R6", 22'h000000, 0, 1, 0, '0, 0, 0, 1, 0, 0);
    // environment refusals
    cyc("R8", 22'h100000, 0, 1, 0, '0, 1, 0, 1, 1, 0);
    cyc("R8", 22'h100000, 0, 1, 0, '0, 1, 0, 0, 0, 0);
    cyc("R8", 22'h100000, 0, 1, 0, '0, 1, 0, 1, 0, 1);
    cyc("R9", 22'h100000, 0, 0, 0, '0, 1, 0, 1, 0, 1);
    cyc("R10", 22'h100000, 0, 1, 0, '0, 1, 0, 1, 1, 1);
    cyc("R10", 22'h100000, 0, 0, 0, '0, 1, 0, 1, 1, 0);
    cyc("R9", 22'h100000, 0, 1, 0, '0, 1, 0, 1, 0, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [66:0] pd;
      bit ld;
      logic [21:0] a;
      pd = {$urandom(), $urandom(), $urandom()};
      ld = ($urandom_range(0, 15) == 0);
      a  = ($urandom_range(0, 1) == 1) ? 22'($urandom()) :
           ($urandom_range(0, 1) == 1 ? 22'h3F0000 | 22'($urandom_range(0, 16'hFFFF))
                                      : 22'($urandom_range(0, 16'hFFFF)));
      cyc("RND", a, $urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0, ld, pd,
          $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 15) != 0, $urandom_range(0, 9) == 0,
          $urandom_range(0, 5) == 0);
    end
    cyc("END", 22'h0, 0, 0, 0, '0, 1, 0, 1, 0, 0);
    @(negedge clk);
    compare();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule